// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Controller

This block is the control and status corner of a display link transmitter. It watches two asynchronous detection lines: a receiver-sense line that reports a powered receiver on the link, and a hot-plug line from the connector. Both lines are synchronized into the core clock. A sticky, active-low interrupt flag drops when the selected line changes level. Software clears the flag by writing a one to it.

A programmable mux chooses what drives the monitor-sense output pin: the flag, either synchronized detection line, or a constant high. The block also gates the horizontal and vertical sync signals on their way to the link. When a sync enable is cleared, that sync output is held low.

Software reaches the block through a simple synchronous register bus. The bus has an address, write data, a write strobe and a combinational read-data return. The configuration word sits at address 0 and the status word at address 1.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: After reset the configuration word (address 0) reads 0x0B and the status word (address 1) reads 0x01. The configuration layout is bit0 hsync enable, bit1 vsync enable, bit2 trigger select, and bits 5:3 sense select. The status layout is bit0 interrupt flag, bit1 synchronized receiver-sense, and bit2 synchronized hot-plug.
- R2: A level change on the selected detection line, applied to the input, reads as status bit0 = 0 after the third rising clock edge.
- R3: Writing status with bit0 = 1 returns the flag to 1 on the next edge. Writing bit0 = 0 leaves the flag unchanged. The flag never returns to 1 without such a write.
- R4: If a change on the selected line and a clear write fall on the same edge, the flag is 0 after that edge.
- R5: With trigger select 0 the flag tracks receiver-sense only. With trigger select 1 it tracks hot-plug only. Changes on the other line leave the flag untouched.
- R6: Toggling trigger select while both lines are steady does not lower the flag.
- R7: Sense select 000 and every code 1xx drive the sense output high. Code 001 drives the flag, code 010 drives synchronized receiver-sense, and code 011 drives synchronized hot-plug.
- R8: With hsync enable 0 the hsync output is low. With hsync enable 1 it equals the hsync input in the same cycle.
- R9: With vsync enable 0 the vsync output is low. With vsync enable 1 it equals the vsync input in the same cycle.
- R10: Status bits 1 and 2 follow their inputs two edges late. Writes to those bits have no effect.
- R11: Addresses other than 0 and 1 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for addr |
| rxSenseIn | input | 1 | Asynchronous receiver-sense line |
| hotPlugIn | input | 1 | Asynchronous hot-plug line |
| hsyncIn | input | 1 | Horizontal sync from the video source |
| vsyncIn | input | 1 | Vertical sync from the video source |
| hsyncOut | output | 1 | Gated horizontal sync |
| vsyncOut | output | 1 | Gated vertical sync |
| senseOut | output | 1 | Monitor-sense pin driven by the selected source |

## Verification
The assertions assume that a write strobe lasts a single cycle and that the address and data are valid while it is high. They also assume that the detection lines are low while reset is held, so the first synchronized samples match the reset value of the previous-sample registers. The bench drives every input one time unit after a rising edge and keeps both detection lines low through reset. Its random phase changes the lines no more often than once per cycle and issues only single-cycle writes. It still produces same-edge collisions between line changes and clear writes.

// File: rtl/hpdc_pkg.sv
package hpdc_pkg;

  localparam int NUM_LINES = 2;
  localparam int LINE_RX   = 0;
  localparam int LINE_HP   = 1;

  localparam logic [2:0] SNS_FORCE = 3'b000;
  localparam logic [2:0] SNS_FLAG  = 3'b001;
  localparam logic [2:0] SNS_RX    = 3'b010;
  localparam logic [2:0] SNS_HP    = 3'b011;

  // configuration word, hsyncEn in bit 0
  typedef struct packed {
    logic [2:0] senseSel;
    logic       trigSel;
    logic       vsyncEn;
    logic       hsyncEn;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{senseSel: SNS_FLAG, trigSel: 1'b0,
                                 vsyncEn: 1'b1, hsyncEn: 1'b1};

  // strobes from control to datapath
  typedef struct packed {
    logic clrFlag;
  } strobe_t;

  // status word, intFlag in bit 0
  typedef struct packed {
    logic hpSync;
    logic rxSync;
    logic intFlag;
  } stat_t;

endpackage

// File: rtl/hpdc_ctrl.sv
module hpdc_ctrl
  import hpdc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CFG_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  stat_t             stat,
  output cfg_t              cfg,
  output strobe_t           strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int CFG_W  = $bits(cfg_t);
  localparam int STAT_W = $bits(stat_t);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic cfgHit;
  logic statHit;

  assign cfgHit  = (addr == CFG_A);
  assign statHit = (addr == STAT_A);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RESET;
    end else if (wrEn && cfgHit) begin
      cfg <= cfg_t'(wrData[CFG_W-1:0]);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.clrFlag = wrEn && statHit && wrData[0];
  end

  always_comb begin
    rdData = '0;
    if (cfgHit) begin
      rdData[CFG_W-1:0] = cfg;
    end else if (statHit) begin
      rdData[STAT_W-1:0] = stat;
    end
  end

endmodule

// File: rtl/hpdc_datapath.sv
module hpdc_datapath
  import hpdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  strobe_t strobe,
  input  logic    rxSenseIn,
  input  logic    hotPlugIn,
  input  logic    hsyncIn,
  input  logic    vsyncIn,
  output stat_t   stat,
  output logic    selChange,
  output logic    hsyncOut,
  output logic    vsyncOut,
  output logic    senseOut
);

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic [NUM_LINES-1:0] prevLines;
  logic [NUM_LINES-1:0] lineChange;
  logic                 intFlag;

  assign rawLines[LINE_RX] = rxSenseIn;
  assign rawLines[LINE_HP] = hotPlugIn;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = chain[SYNC_STAGES-1];
  end

  // each line keeps its own previous sample, so a trigger switch compares
  // the newly chosen line only against its own history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '0;
    else       prevLines <= syncLines;
  end

  assign lineChange = syncLines ^ prevLines;
  assign selChange  = cfg.trigSel ? lineChange[LINE_HP] : lineChange[LINE_RX];

  // active-low sticky flag, a new change outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intFlag <= 1'b1;
    else if (selChange)      intFlag <= 1'b0;
    else if (strobe.clrFlag) intFlag <= 1'b1;
  end

  always_comb begin
    stat         = '0;
    stat.intFlag = intFlag;
    stat.rxSync  = syncLines[LINE_RX];
    stat.hpSync  = syncLines[LINE_HP];
  end

  always_comb begin
    case (cfg.senseSel)
      SNS_FLAG: senseOut = intFlag;
      SNS_RX:   senseOut = syncLines[LINE_RX];
      SNS_HP:   senseOut = syncLines[LINE_HP];
      default:  senseOut = 1'b1;
    endcase
  end

  assign hsyncOut = hsyncIn & cfg.hsyncEn;
  assign vsyncOut = vsyncIn & cfg.vsyncEn;

endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl
  import hpdc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxSenseIn,
  input  logic              hotPlugIn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              senseOut
);

  cfg_t    cfg;
  strobe_t strobe;
  stat_t   stat;
  logic    selChange;

  hpdc_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CFG_ADDR(0),
    .STAT_ADDR(1)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .addr(addr),
    .wrEn(wrEn),
    .wrData(wrData),
    .stat(stat),
    .cfg(cfg),
    .strobe(strobe),
    .rdData(rdData)
  );

  hpdc_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .cfg(cfg),
    .strobe(strobe),
    .rxSenseIn(rxSenseIn),
    .hotPlugIn(hotPlugIn),
    .hsyncIn(hsyncIn),
    .vsyncIn(vsyncIn),
    .stat(stat),
    .selChange(selChange),
    .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut),
    .senseOut(senseOut)
  );

endmodule

// File: rtl/hpdc_chk.sv
module hpdc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       intFlag,
  input logic       selChange,
  input logic       clrFlag,
  input logic [2:0] senseSel,
  input logic       senseOut,
  input logic       hsyncEn,
  input logic       hsyncOut,
  input logic       vsyncEn,
  input logic       vsyncOut
);

  // R2
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intFlag) |-> $past(selChange));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !selChange) |=> intFlag);

  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(clrFlag));

  // R4
  change_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> !intFlag);

  // R7
  sense_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (senseSel == 3'b000 || senseSel[2]) |-> senseOut);

  // R8
  hsync_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hsyncEn |-> !hsyncOut);

  // R9
  vsync_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncEn |-> !vsyncOut);

endmodule

bind hpd_irq_ctrl hpdc_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .intFlag(stat.intFlag),
  .selChange(selChange),
  .clrFlag(strobe.clrFlag),
  .senseSel(cfg.senseSel),
  .senseOut(senseOut),
  .hsyncEn(cfg.hsyncEn),
  .hsyncOut(hsyncOut),
  .vsyncEn(cfg.vsyncEn),
  .vsyncOut(vsyncOut)
);

// File: tb/test_hpd_irq_ctrl.sv
module test_hpd_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              rxSenseIn = 1'b0;
  logic              hotPlugIn = 1'b0;
  logic              hsyncIn = 1'b0;
  logic              vsyncIn = 1'b0;
  logic              hsyncOut;
  logic              vsyncOut;
  logic              senseOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) i_hpd_irq_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .rxSenseIn(rxSenseIn), .hotPlugIn(hotPlugIn),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .senseOut(senseOut)
  );

  // behavioural reference: pipelines held as integer queues
  int mHen, mVen, mTrig, mSel, mFlag;
  int rxPipe[$];
  int hpPipe[$];
  int mPrevRx, mPrevHp;

  task automatic modelReset();
    mHen = 1; mVen = 1; mTrig = 0; mSel = 1; mFlag = 1;
    rxPipe = '{0, 0};
    hpPipe = '{0, 0};
    mPrevRx = 0; mPrevHp = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      int rxNow, hpNow, chg;
      rxNow = rxPipe[1];
      hpNow = hpPipe[1];
      chg = (mTrig != 0) ? int'(hpNow != mPrevHp) : int'(rxNow != mPrevRx);
      if (chg != 0) mFlag = 0;
      else if (wrEn && addr == 1 && wrData[0]) mFlag = 1;
      mPrevRx = rxNow;
      mPrevHp = hpNow;
      void'(rxPipe.pop_back());
      rxPipe.push_front(int'(rxSenseIn));
      void'(hpPipe.pop_back());
      hpPipe.push_front(int'(hotPlugIn));
      if (wrEn && addr == 0) begin
        mHen = int'(wrData[0]); mVen = int'(wrData[1]);
        mTrig = int'(wrData[2]); mSel = int'(wrData[5:3]);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expRd, expSense;
      case (mSel)
        1: expSense = mFlag;
        2: expSense = rxPipe[1];
        3: expSense = hpPipe[1];
        default: expSense = 1;
      endcase
      if (addr == 0) expRd = mHen | (mVen << 1) | (mTrig << 2) | (mSel << 3);
      else if (addr == 1) expRd = mFlag | (rxPipe[1] << 1) | (hpPipe[1] << 2);
      else expRd = 0;
      check("R7 sense", int'(senseOut), expSense);
      check("R8 hsync", int'(hsyncOut), mHen & int'(hsyncIn));
      check("R9 vsync", int'(vsyncOut), mVen & int'(vsyncIn));
      check(addr == 1 ? "R2 status" : "R11 read", int'(rdData), expRd);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    addr = ADDR_W'(a); wrData = DATA_W'(d); wrEn = 1'b1;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(string tag, int a, int exp);
    addr = ADDR_W'(a);
    @(negedge clk);
    check(tag, int'(rdData), exp);
    step(1);
  endtask

  task automatic pinCheck(string tag, logic v, int exp);
    @(negedge clk);
    check(tag, int'(v), exp);
    step(1);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    rdCheck("R1 cfg reset", 0, 8'h0B);
    rdCheck("R1 status reset", 1, 8'h01);
    // receiver-sense rises, trigger select 0
    rxSenseIn = 1'b1;
    addr = 1;
    step(2);
    @(negedge clk); check("R2 flag not yet low", int'(rdData[0]), 1);
    step(1);
    rdCheck("R2 R10 flag low rx set", 1, 8'h02);
    wr(1, 8'h00);
    rdCheck("R3 write zero no clear", 1, 8'h02);
    wr(1, 8'h01);
    rdCheck("R3 clear", 1, 8'h03);
    hotPlugIn = 1'b1;
    step(4);
    rdCheck("R5 unselected line ignored", 1, 8'h07);
    wr(0, 8'h0F);
    step(3);
    rdCheck("R6 no spurious on switch", 1, 8'h07);
    wr(0, 8'h0B);
    step(3);
    rdCheck("R6 no spurious on switch back", 1, 8'h07);
    wr(0, 8'h0F);
    hotPlugIn = 1'b0;
    step(3);
    rdCheck("R5 hot-plug tracked", 1, 8'h02);
    wr(1, 8'h01);
    // change and clear on the same edge
    hotPlugIn = 1'b1;
    step(2);
    wr(1, 8'h01);
    rdCheck("R4 change beats clear", 1, 8'h06);
    wr(1, 8'h07);
    rdCheck("R3 R10 clear, line bits not writable", 1, 8'h07);
    rxSenseIn = 1'b0;
    step(3);
    rdCheck("R5 R10 rx ignored under hp select", 1, 8'h05);
    wr(0, 8'h17);
    pinCheck("R7 code 010 rx", senseOut, 0);
    wr(0, 8'h1F);
    pinCheck("R7 code 011 hp", senseOut, 1);
    wr(0, 8'h07);
    pinCheck("R7 code 000 high", senseOut, 1);
    wr(0, 8'h37);
    pinCheck("R7 code 110 high", senseOut, 1);
    hotPlugIn = 1'b0;
    wr(0, 8'h0F);
    step(3);
    pinCheck("R7 code 001 flag", senseOut, 0);
    hsyncIn = 1'b1; vsyncIn = 1'b1;
    wr(0, 8'h0E);
    pinCheck("R8 hsync gated", hsyncOut, 0);
    pinCheck("R9 vsync passes", vsyncOut, 1);
    wr(0, 8'h0D);
    pinCheck("R8 hsync passes", hsyncOut, 1);
    pinCheck("R9 vsync gated", vsyncOut, 0);
    wr(5, 8'hFF);
    rdCheck("R11 unmapped reads zero", 5, 0);
    rdCheck("R11 cfg untouched", 0, 8'h0D);
    rdCheck("R11 status untouched", 1, 8'h00);
    // random phase, checked by the per-cycle comparator
    for (int i = 0; i < 3000; i++) begin
      rxSenseIn = ($urandom_range(0, 7) == 0) ? ~rxSenseIn : rxSenseIn;
      hotPlugIn = ($urandom_range(0, 7) == 0) ? ~hotPlugIn : hotPlugIn;
      hsyncIn = 1'($urandom);
      vsyncIn = 1'($urandom);
      addr = ADDR_W'($urandom_range(0, 3));
      wrData = DATA_W'($urandom);
      wrEn = ($urandom_range(0, 3) == 0);
      step(1);
      wrEn = 1'b0;
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule